// File: doc/BRIEF.md
# Configuration-Write Bitstream Snooper

This block sits passively on a PCI-style multiplexed address/data bus and extracts an FPGA serial configuration stream that a host encodes in the address of configuration-space write cycles. Because nothing on the card claims those writes, the initiator abandons each one after a few clocks; the block therefore takes everything it needs from the single address-phase clock, the first clock on which the frame line is active. It drives no bus signal at all.

Each recognised write either advances a serial identification register or delivers one step of configuration data. Two address bits carry the identification channel: one enables a shift and the other is the bit shifted in. The identification register may be longer than the expected vendor code; only its most recently shifted bits are compared. Configuration clock and data levels, taken from two further address bits, reach the outputs only while that comparison holds, so one host can broadcast a stream to every slot and only the card carrying the right code responds.

Top module: `cfg_snoop`

## Requirements
- R1: A write is recognised only on the clock edge where `bus_frame_n` is low and was high on the previous edge, with `bus_cbe_n` equal to 4'b1011 on that edge; any other command, and any later clock of a frame, leaves all three outputs unchanged.
- R2: Address bits are sampled only on the recognising edge; values on `bus_ad` during the following data-phase clocks have no effect.
- R3: A recognised write with `bus_ad[3]` = 1 shifts `bus_ad[2]` into the least significant end of the identification register (older bits move up) and does not load `cfg_clk` or `cfg_data` from the address.
- R4: `id_match` is 1 exactly when the newest ID_W bits of the identification register (default 16 bits) equal EXP_ID (default 16'hC3A5, oldest bit first), updated one edge after the shift; older bits of the longer register (default 24 bits) do not matter.
- R5: A recognised write with `bus_ad[3]` = 0 while `id_match` is 1 sets `cfg_clk` to `bus_ad[1]` and `cfg_data` to `bus_ad[0]` on that edge.
- R6: While `id_match` is 0, `cfg_clk` is 0 and `cfg_data` keeps its last value; a shift that breaks a match forces `cfg_clk` low on the same edge.
- R7: A synchronous reset (`rst` high) clears the identification register and all three outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_frame_n | input | 1 | Active-low cycle frame |
| bus_cbe_n | input | 4 | Command / byte-enable lines |
| bus_ad | input | 32 | Multiplexed address/data lines |
| cfg_clk | output | 1 | Configuration clock level |
| cfg_data | output | 1 | Configuration serial data level |
| id_match | output | 1 | Identification register holds the expected code |

## Verification
Two functions meet on one edge when a shift write breaks an established match while `cfg_clk` is high: the identification update and the forced clock drop must both land on that edge. The bench provokes this by shifting an extra bit after configuration data has left `cfg_clk` at 1, and judges it with its behavioural model, which must show `id_match` and `cfg_clk` both falling one edge after the write while `cfg_data` keeps its level. Long frames with changing data-phase values and non-configuration commands are mixed in to show that only the recognising edge counts.

// File: rtl/cfgsnp_pkg.sv
package cfgsnp_pkg;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;

  typedef struct packed {
    logic shift_en;
    logic shift_bit;
    logic step_clk;
    logic step_dat;
  } snoop_fields_t;
endpackage

// File: rtl/cfgsnp_cycle_det.sv
module cfgsnp_cycle_det
  import cfgsnp_pkg::*;
#(
  parameter int AD_W     = 32,
  parameter int DAT_POS  = 0,
  parameter int CLK_POS  = 1,
  parameter int SBIT_POS = 2,
  parameter int SEN_POS  = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_frame_n,
  input  logic [3:0]      bus_cbe_n,
  input  logic [AD_W-1:0] bus_ad,
  output logic            wr_hit,
  output snoop_fields_t   fld
);
  logic frame_q;

  // previous frame level; inactive after reset
  always_ff @(posedge clk) begin
    if (rst) frame_q <= 1'b1;
    else     frame_q <= bus_frame_n;
  end

  always_comb begin
    wr_hit        = !bus_frame_n && frame_q && (bus_cbe_n == CMD_CFG_WR);
    fld.shift_en  = bus_ad[SEN_POS];
    fld.shift_bit = bus_ad[SBIT_POS];
    fld.step_clk  = bus_ad[CLK_POS];
    fld.step_dat  = bus_ad[DAT_POS];
  end
endmodule

// File: rtl/cfgsnp_id_reg.sv
module cfgsnp_id_reg #(
  parameter int              SR_W   = 24,
  parameter int              ID_W   = 16,
  parameter logic [ID_W-1:0] EXP_ID = 16'hC3A5
) (
  input  logic clk,
  input  logic rst,
  input  logic shift_go,
  input  logic shift_bit,
  output logic id_match,
  output logic id_match_nxt
);
  logic [SR_W-1:0] sr_q, sr_nxt;

  generate
    if (SR_W > 1) begin : g_multi
      always_comb sr_nxt = shift_go ? {sr_q[SR_W-2:0], shift_bit} : sr_q;
    end else begin : g_single
      always_comb sr_nxt = shift_go ? shift_bit : sr_q;
    end
  endgenerate

  always_comb id_match_nxt = (sr_nxt[ID_W-1:0] == EXP_ID);

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q     <= '0;
      id_match <= 1'b0;
    end else begin
      sr_q     <= sr_nxt;
      id_match <= id_match_nxt;
    end
  end
endmodule

// File: rtl/cfgsnp_cfg_out.sv
module cfgsnp_cfg_out
  import cfgsnp_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_hit,
  input  snoop_fields_t fld,
  input  logic          id_match,
  input  logic          id_match_nxt,
  output logic          cfg_clk,
  output logic          cfg_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_clk  <= 1'b0;
      cfg_data <= 1'b0;
    end else if (wr_hit) begin
      if (fld.shift_en) begin
        if (!id_match_nxt) cfg_clk <= 1'b0;
      end else if (id_match) begin
        cfg_clk  <= fld.step_clk;
        cfg_data <= fld.step_dat;
      end else begin
        cfg_clk <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cfg_snoop.sv
module cfg_snoop
  import cfgsnp_pkg::*;
#(
  parameter int              AD_W     = 32,
  parameter int              SR_W     = 24,
  parameter int              ID_W     = 16,
  parameter logic [ID_W-1:0] EXP_ID   = 16'hC3A5,
  parameter int              DAT_POS  = 0,
  parameter int              CLK_POS  = 1,
  parameter int              SBIT_POS = 2,
  parameter int              SEN_POS  = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_frame_n,
  input  logic [3:0]      bus_cbe_n,
  input  logic [AD_W-1:0] bus_ad,
  output logic            cfg_clk,
  output logic            cfg_data,
  output logic            id_match
);
  logic          wr_hit;
  snoop_fields_t fld;
  logic          id_match_nxt;
  logic          shift_go;

  cfgsnp_cycle_det #(
    .AD_W(AD_W), .DAT_POS(DAT_POS), .CLK_POS(CLK_POS),
    .SBIT_POS(SBIT_POS), .SEN_POS(SEN_POS)
  ) u_det (
    .clk(clk), .rst(rst), .bus_frame_n(bus_frame_n),
    .bus_cbe_n(bus_cbe_n), .bus_ad(bus_ad),
    .wr_hit(wr_hit), .fld(fld)
  );

  assign shift_go = wr_hit && fld.shift_en;

  cfgsnp_id_reg #(
    .SR_W(SR_W), .ID_W(ID_W), .EXP_ID(EXP_ID)
  ) u_id (
    .clk(clk), .rst(rst), .shift_go(shift_go), .shift_bit(fld.shift_bit),
    .id_match(id_match), .id_match_nxt(id_match_nxt)
  );

  cfgsnp_cfg_out u_out (
    .clk(clk), .rst(rst), .wr_hit(wr_hit), .fld(fld),
    .id_match(id_match), .id_match_nxt(id_match_nxt),
    .cfg_clk(cfg_clk), .cfg_data(cfg_data)
  );
endmodule

// File: rtl/cfgsnp_chk.sv
module cfgsnp_chk #(
  parameter int AD_W    = 32,
  parameter int DAT_POS = 0,
  parameter int CLK_POS = 1,
  parameter int SEN_POS = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            bus_frame_n,
  input logic [3:0]      bus_cbe_n,
  input logic [AD_W-1:0] bus_ad,
  input logic            cfg_clk,
  input logic            cfg_data,
  input logic            id_match
);
  logic fr_prev;
  logic hit;

  always_ff @(posedge clk) begin
    if (rst) fr_prev <= 1'b1;
    else     fr_prev <= bus_frame_n;
  end

  assign hit = !bus_frame_n && fr_prev && (bus_cbe_n == 4'b1011);

  // R1
  quiet_without_hit_chk: assert property (@(posedge clk) disable iff (rst)
    !hit |=> ($stable(cfg_clk) && $stable(cfg_data) && $stable(id_match)));

  // R5
  data_step_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && !bus_ad[SEN_POS] && id_match) |=>
      (cfg_clk == $past(bus_ad[CLK_POS]) && cfg_data == $past(bus_ad[DAT_POS])));

  // R6
  clk_low_unmatched_chk: assert property (@(posedge clk) disable iff (rst)
    !id_match |-> !cfg_clk);

  // R6
  data_hold_unmatched_chk: assert property (@(posedge clk) disable iff (rst)
    !id_match |=> $stable(cfg_data));

  // R3
  shift_keeps_data_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && bus_ad[SEN_POS]) |=> $stable(cfg_data));

  // R7
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!cfg_clk && !cfg_data && !id_match));
endmodule

bind cfg_snoop cfgsnp_chk #(
  .AD_W(AD_W), .DAT_POS(DAT_POS), .CLK_POS(CLK_POS), .SEN_POS(SEN_POS)
) u_chk (
  .clk(clk), .rst(rst), .bus_frame_n(bus_frame_n), .bus_cbe_n(bus_cbe_n),
  .bus_ad(bus_ad), .cfg_clk(cfg_clk), .cfg_data(cfg_data), .id_match(id_match)
);

// File: tb/cfg_snoop_bench.sv
module cfg_snoop_bench;
  localparam logic [15:0] EXP = 16'hC3A5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_frame_n = 1'b1;
  logic [3:0]  bus_cbe_n = 4'hF;
  logic [31:0] bus_ad = '0;
  logic        cfg_clk, cfg_data, id_match;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cfg_snoop u_cfg_snoop (
    .clk(clk), .rst(rst), .bus_frame_n(bus_frame_n), .bus_cbe_n(bus_cbe_n),
    .bus_ad(bus_ad), .cfg_clk(cfg_clk), .cfg_data(cfg_data), .id_match(id_match)
  );

  // behavioural reference
  bit        m_fprev = 1'b1;
  bit [23:0] m_sr = '0;
  bit        m_match = 1'b0, m_clk = 1'b0, m_dat = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      m_fprev = 1'b1; m_sr = '0; m_match = 1'b0; m_clk = 1'b0; m_dat = 1'b0;
    end else begin
      if (!bus_frame_n && m_fprev && bus_cbe_n == 4'b1011) begin
        if (bus_ad[3]) begin
          m_sr = {m_sr[22:0], bus_ad[2]};
          m_match = (m_sr[15:0] == EXP);
          if (!m_match) m_clk = 1'b0;
        end else if (m_match) begin
          m_clk = bus_ad[1];
          m_dat = bus_ad[0];
        end else begin
          m_clk = 1'b0;
        end
      end
      m_fprev = bus_frame_n;
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model, mid high phase
  always @(posedge clk) begin
    #1;
    if (!done) begin
      check("R4 id_match vs model", id_match, m_match);
      check("R5 cfg_clk vs model", cfg_clk, m_clk);
      check("R6 cfg_data vs model", cfg_data, m_dat);
    end
  end

  task automatic bus_cycle(input logic [3:0] cmd, input logic [31:0] adr,
                           input int dcycles, input logic [31:0] dpat);
    @(negedge clk);
    bus_frame_n = 1'b0; bus_cbe_n = cmd; bus_ad = adr;
    for (int i = 0; i < dcycles; i++) begin
      @(negedge clk);
      bus_cbe_n = 4'h0; bus_ad = dpat ^ i;
    end
    @(negedge clk);
    bus_frame_n = 1'b1; bus_cbe_n = 4'hF; bus_ad = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic shift_in(input logic b);
    bus_cycle(4'b1011, {28'h0, 1'b1, b, 2'b00}, 5, 32'hFFFF_FFF0);
  endtask

  task automatic step(input logic c, input logic d);
    bus_cycle(4'b1011, {30'h0, c, d}, 5, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R7 reset id_match", id_match, 1'b0);
    check("R7 reset cfg_clk", cfg_clk, 1'b0);
    check("R7 reset cfg_data", cfg_data, 1'b0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    step(1'b1, 1'b1);
    check("R6 unmatched clk low", cfg_clk, 1'b0);
    check("R6 unmatched data held", cfg_data, 1'b0);

    // older junk bits, then the code oldest bit first
    for (int i = 0; i < 5; i++) shift_in(i[0]);
    for (int i = 15; i >= 0; i--) shift_in(EXP[i]);
    check("R4 match after code", id_match, 1'b1);
    check("R3 shift leaves clk", cfg_clk, 1'b0);

    step(1'b1, 1'b0);
    check("R5 clk from address", cfg_clk, 1'b1);
    check("R5 data from address", cfg_data, 1'b0);
    step(1'b0, 1'b1);
    check("R5 clk low step", cfg_clk, 1'b0);
    check("R5 data high step", cfg_data, 1'b1);
    step(1'b1, 1'b1);

    // non-config commands with bits clear: ignored
    bus_cycle(4'b1010, 32'h0, 5, 32'h0);
    bus_cycle(4'b0111, 32'h0, 5, 32'h0);
    check("R1 other cmd clk kept", cfg_clk, 1'b1);
    check("R1 other cmd data kept", cfg_data, 1'b1);

    // data phase carries shift/step bits: must not count
    bus_cycle(4'b1011, 32'h0000_0003, 8, 32'h0000_0008);
    check("R2 data phase ignored match", id_match, 1'b1);
    check("R2 data phase ignored clk", cfg_clk, 1'b1);

    // shift that breaks the match while clk is high
    shift_in(1'b1);
    check("R6 broken match flag", id_match, 1'b0);
    check("R6 broken match clk low", cfg_clk, 1'b0);
    check("R6 broken match data held", cfg_data, 1'b1);

    // restore match via long register, then reset mid-stream
    for (int i = 15; i >= 0; i--) shift_in(EXP[i]);
    step(1'b1, 1'b0);
    check("R4 rematch", id_match, 1'b1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R7 mid reset match", id_match, 1'b0);
    check("R7 mid reset clk", cfg_clk, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule